// File: doc/BRIEF.md
# Inter-Core Message Send Engine

This block takes one 64-bit send command at a time and turns it into register accesses on a target core. The accesses go over a simple request/response register bus. The command selects a target core and carries an address or a vector, a 4-bit byte-keep mask and a 32-bit payload.

There are three command kinds:

- **Interrupt send.** Posts a one-hot vector to the target's status-set register and signals the target's interrupt line.
- **Mailbox send.** Writes one of the target's eight mailbox words.
- **Free-address send.** Writes any 16-bit address on the target.

When the keep mask is nonzero, a mailbox or free-address send first reads the target word. It then merges that word with the payload and writes the result back. A byte whose mask bit is set keeps its old value, which is the opposite of the usual byte-enable sense. When the mask is zero, the read is skipped and the whole payload is written.

Commands that cannot be carried out are dropped without touching the bus, and a one-cycle error pulse is raised. These are a reserved kind, a narrow write of a mailbox or free-address send, and a core number outside the implemented range.

Top module: `core_msg_sender`

## Requirements
- R1: After reset, busy, req_valid, done, err and irq_raise are all low.
- R2: The target core is cmd_data[25:16]; every bus request of a command carries it on req_core, and irq_core carries it on an interrupt send's done cycle.
- R3: Interrupt send (cmd_kind 0, any width) makes no read and writes 1 << cmd_data[4:0] to address 0x1008. irq_raise pulses together with done.
- R4: Mailbox send (cmd_kind 1) targets address 0x1020 + 4*cmd_data[4:2]. Bits 1:0 and 31 of the command do not change the access.
- R5: Free-address send (cmd_kind 2) targets address cmd_data[15:0].
- R6: With a nonzero keep mask cmd_data[30:27], a mailbox or free-address send reads the target address once and then writes it once. Byte i (bits 8i+7:8i) keeps the read value when mask bit i is 1 and takes the payload byte when it is 0.
- R7: With a zero keep mask, a mailbox or free-address send makes no read and writes the whole payload.
- R8: The payload is cmd_data[63:32].
- R9: cmd_kind 3, or a mailbox or free-address send with cmd_wide low, is dropped. Nothing goes on the bus, and err pulses for one cycle in the cycle after acceptance.
- R10: A command whose core field is not below NUM_CORES is dropped. Nothing goes on the bus, err pulses once, and no request ever carries such a core.
- R11: A command is accepted only while busy is low. busy stays high from the cycle after acceptance until done. cmd_valid during busy is ignored, and a pending request holds its fields until rsp_valid.
- R12: done pulses for one cycle, the cycle after the final write's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered (accepted when busy is low) |
| cmd_kind | input | 2 | 0 interrupt, 1 mailbox, 2 free address, 3 reserved |
| cmd_wide | input | 1 | Command arrived as a full 64-bit write |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle drop pulse |
| irq_raise | output | 1 | Raise the target's interrupt (with done) |
| irq_core | output | CORE_W | Core whose interrupt is raised |
| req_valid | output | 1 | Bus request pending |
| req_write | output | 1 | 1 write, 0 read |
| req_core | output | CORE_W | Target core of the request |
| req_addr | output | ADDR_W | Target register address |
| req_wdata | output | WORD_W | Write data |
| rsp_valid | input | 1 | Response for the pending request |
| rsp_rdata | input | WORD_W | Read data returned |

## Verification
Two kinds of fault can be caught in the one to five cycles a command lasts: a wrong sequencer state or a bad latched field. A skipped or extra read changes the number of bus accesses. A wrong latched mask, old word or payload shows up as a wrong write word. A wrong address decode shows up on req_addr in the first request cycle.

Stalling the response reveals a corrupt busy state or lost held fields. The test then fires a second command into the busy window. That second command must leave no trace on the bus.

// File: rtl/core_msg_pkg.sv
package core_msg_pkg;

   typedef enum logic [1:0] {
      KIND_INT  = 2'd0,
      KIND_MAIL = 2'd1,
      KIND_ANY  = 2'd2,
      KIND_RSVD = 2'd3
   } msg_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_MERGE = 3'd2,
      ST_WRITE = 3'd3,
      ST_DONE  = 3'd4
   } seq_state_e;

   // fixed field positions inside the 64-bit command word
   localparam int CMD_W      = 64;
   localparam int CORE_LSB   = 16;
   localparam int KEEP_LSB   = 27;
   localparam int KEEP_W     = 4;
   localparam int PAY_LSB    = 32;
   localparam int VEC_W      = 5;

endpackage

// File: rtl/msg_cmd_decode.sv
module msg_cmd_decode
   import core_msg_pkg::*;
#(
   parameter int                NUM_CORES = 16,
   parameter int                CORE_W    = 10,
   parameter int                ADDR_W    = 16,
   parameter int                WORD_W    = 32,
   parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1008,
   parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1020
) (
   input  logic [1:0]        kind,
   input  logic              wide,
   input  logic [CMD_W-1:0]  cmd,
   output logic [CORE_W-1:0] core,
   output logic [ADDR_W-1:0] addr,
   output logic [KEEP_W-1:0] keep,
   output logic [WORD_W-1:0] payload,
   output logic [WORD_W-1:0] vec_word,
   output logic              is_int,
   output logic              bad
);

   localparam logic [CORE_W:0] CORE_LIMIT = (CORE_W+1)'(NUM_CORES);

   logic unused_cmd_bits;
   assign unused_cmd_bits = ^{cmd[26], cmd[31]};

   msg_kind_e kind_e;
   assign kind_e   = msg_kind_e'(kind);

   assign core     = cmd[CORE_LSB +: CORE_W];
   assign payload  = cmd[PAY_LSB +: WORD_W];
   assign vec_word = WORD_W'(1) << cmd[VEC_W-1:0];
   assign is_int   = (kind_e == KIND_INT);
   assign keep     = is_int ? '0 : cmd[KEEP_LSB +: KEEP_W];

   always_comb begin
      unique case (kind_e)
         KIND_INT:  addr = SET_ADDR;
         KIND_MAIL: addr = MBOX_BASE + ADDR_W'({cmd[4:2], 2'b00});
         KIND_ANY:  addr = cmd[ADDR_W-1:0];
         default:   addr = '0;
      endcase
   end

   logic kind_bad, width_bad, core_bad;
   assign kind_bad  = (kind_e == KIND_RSVD);
   assign width_bad = !wide && !is_int;
   assign core_bad  = ({1'b0, core} >= CORE_LIMIT);
   assign bad       = kind_bad || width_bad || core_bad;

endmodule

// File: rtl/msg_byte_merge.sv
module msg_byte_merge #(
   parameter int WORD_W = 32,
   parameter int BYTES  = WORD_W / 8
) (
   input  logic [WORD_W-1:0] old_word,
   input  logic [WORD_W-1:0] new_word,
   input  logic [BYTES-1:0]  keep,
   output logic [WORD_W-1:0] merged
);

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
   end

endmodule

// File: rtl/msg_seq.sv
module msg_seq
   import core_msg_pkg::*;
#(
   parameter int CORE_W = 10,
   parameter int ADDR_W = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              dec_bad,
   input  logic              dec_is_int,
   input  logic [KEEP_W-1:0] dec_keep,
   input  logic [CORE_W-1:0] dec_core,
   input  logic [ADDR_W-1:0] dec_addr,
   input  logic [WORD_W-1:0] dec_payload,
   input  logic [WORD_W-1:0] dec_vec,
   input  logic [WORD_W-1:0] merged,
   output logic [WORD_W-1:0] old_q,
   output logic [WORD_W-1:0] payload_q,
   output logic [KEEP_W-1:0] keep_q,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_rdata,
   output logic              req_valid,
   output logic              req_write,
   output logic [CORE_W-1:0] req_core,
   output logic [ADDR_W-1:0] req_addr,
   output logic [WORD_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              irq_raise,
   output logic [CORE_W-1:0] irq_core
);

   seq_state_e        state_q;
   logic [CORE_W-1:0] core_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;
   logic              int_q;
   logic              err_q;
   logic              accept;

   assign accept = cmd_valid && (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         core_q    <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
         old_q     <= '0;
         payload_q <= '0;
         keep_q    <= '0;
         int_q     <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         err_q <= accept && dec_bad;
         unique case (state_q)
            ST_IDLE: begin
               if (accept && !dec_bad) begin
                  core_q    <= dec_core;
                  addr_q    <= dec_addr;
                  payload_q <= dec_payload;
                  keep_q    <= dec_keep;
                  int_q     <= dec_is_int;
                  old_q     <= '0;
                  if (dec_is_int) begin
                     wdata_q <= dec_vec;
                     state_q <= ST_WRITE;
                  end else if (dec_keep != '0) begin
                     state_q <= ST_READ;
                  end else begin
                     state_q <= ST_MERGE;
                  end
               end
            end
            ST_READ: begin
               if (rsp_valid) begin
                  old_q   <= rsp_rdata;
                  state_q <= ST_MERGE;
               end
            end
            ST_MERGE: begin
               wdata_q <= merged;
               state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (rsp_valid) state_q <= ST_DONE;
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign req_write = (state_q == ST_WRITE);
   assign req_core  = core_q;
   assign req_addr  = addr_q;
   assign req_wdata = wdata_q;
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign err       = err_q;
   assign irq_raise = done && int_q;
   assign irq_core  = core_q;

endmodule

// File: rtl/core_msg_sender.sv
module core_msg_sender
   import core_msg_pkg::*;
#(
   parameter int                NUM_CORES = 16,
   parameter int                CORE_W    = 10,
   parameter int                ADDR_W    = 16,
   parameter int                WORD_W    = 32,
   parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1008,
   parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_kind,
   input  logic              cmd_wide,
   input  logic [63:0]       cmd_data,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              irq_raise,
   output logic [CORE_W-1:0] irq_core,
   output logic              req_valid,
   output logic              req_write,
   output logic [CORE_W-1:0] req_core,
   output logic [ADDR_W-1:0] req_addr,
   output logic [WORD_W-1:0] req_wdata,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_rdata
);

   localparam int BYTES = WORD_W / 8;

   if (WORD_W != PAY_LSB) begin : g_bad_word
      $error("WORD_W must equal the payload width of the command");
   end
   if (BYTES != KEEP_W) begin : g_bad_keep
      $error("keep mask width must match the number of bytes");
   end
   if (CORE_W < 1 || CORE_W > KEEP_LSB - CORE_LSB - 1) begin : g_bad_core_w
      $error("CORE_W does not fit the command core field");
   end
   if (NUM_CORES < 1 || NUM_CORES > (1 << CORE_W)) begin : g_bad_cores
      $error("NUM_CORES out of range for CORE_W");
   end
   if (ADDR_W != 16) begin : g_bad_addr
      $error("ADDR_W must be 16");
   end

   logic [CORE_W-1:0] dec_core;
   logic [ADDR_W-1:0] dec_addr;
   logic [KEEP_W-1:0] dec_keep;
   logic [WORD_W-1:0] dec_payload;
   logic [WORD_W-1:0] dec_vec;
   logic              dec_is_int;
   logic              dec_bad;
   logic [WORD_W-1:0] old_q;
   logic [WORD_W-1:0] payload_q;
   logic [KEEP_W-1:0] keep_q;
   logic [WORD_W-1:0] merged;

   msg_cmd_decode #(
      .NUM_CORES (NUM_CORES),
      .CORE_W    (CORE_W),
      .ADDR_W    (ADDR_W),
      .WORD_W    (WORD_W),
      .SET_ADDR  (SET_ADDR),
      .MBOX_BASE (MBOX_BASE)
   ) i_decode (
      .kind     (cmd_kind),
      .wide     (cmd_wide),
      .cmd      (cmd_data),
      .core     (dec_core),
      .addr     (dec_addr),
      .keep     (dec_keep),
      .payload  (dec_payload),
      .vec_word (dec_vec),
      .is_int   (dec_is_int),
      .bad      (dec_bad)
   );

   msg_byte_merge #(
      .WORD_W (WORD_W),
      .BYTES  (BYTES)
   ) i_merge (
      .old_word (old_q),
      .new_word (payload_q),
      .keep     (keep_q),
      .merged   (merged)
   );

   msg_seq #(
      .CORE_W (CORE_W),
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .dec_bad     (dec_bad),
      .dec_is_int  (dec_is_int),
      .dec_keep    (dec_keep),
      .dec_core    (dec_core),
      .dec_addr    (dec_addr),
      .dec_payload (dec_payload),
      .dec_vec     (dec_vec),
      .merged      (merged),
      .old_q       (old_q),
      .payload_q   (payload_q),
      .keep_q      (keep_q),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_core    (req_core),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .busy        (busy),
      .done        (done),
      .err         (err),
      .irq_raise   (irq_raise),
      .irq_core    (irq_core)
   );

endmodule

// File: rtl/core_msg_sender_chk.sv
module core_msg_sender_chk #(
   parameter int NUM_CORES = 16,
   parameter int CORE_W    = 10,
   parameter int ADDR_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              irq_raise,
   input logic              req_valid,
   input logic              req_write,
   input logic [CORE_W-1:0] req_core,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid
);

   localparam logic [CORE_W:0] LIMIT = (CORE_W+1)'(NUM_CORES);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=> (req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_core))) else $error("request dropped or changed while waiting"); // R11

   AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy) else $error("request without busy"); // R11

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy) else $error("error pulse while a command runs"); // R9

   AST_CORE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ({1'b0, req_core} < LIMIT)) else $error("request to unimplemented core"); // R10

   AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_raise |-> done) else $error("interrupt raised outside done"); // R3

   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req_valid && req_write && rsp_valid)) else $error("done without a completed write"); // R12

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err})) else $error("done and err together"); // R12

endmodule

bind core_msg_sender core_msg_sender_chk #(
   .NUM_CORES (NUM_CORES),
   .CORE_W    (CORE_W),
   .ADDR_W    (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .irq_raise (irq_raise),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_core  (req_core),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid)
);

// File: tb/test_core_msg_sender.sv
module test_core_msg_sender;

   localparam int CLK_PERIOD = 10;
   localparam int CORE_W     = 10;
   localparam int ADDR_W     = 16;
   localparam int WORD_W     = 32;
   localparam int NVEC       = 12;

   typedef struct packed {
      logic [1:0]  kind;
      logic        wide;
      logic [63:0] cmd;
      logic [31:0] old;
      logic        exp_err;
      logic [1:0]  exp_reads;
      logic [15:0] exp_addr;
      logic [9:0]  exp_core;
      logic [31:0] exp_data;
      logic        exp_irq;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      // R3 vector 5 to core 3
      '{2'd0, 1'b0, 64'h0000_0000_0003_0005, 32'h0,         1'b0, 2'd0, 16'h1008, 10'd3,  32'h0000_0020, 1'b1},
      // R3 vector 31, wide, payload ignored
      '{2'd0, 1'b1, 64'hFFFF_FFFF_0000_001F, 32'h0,         1'b0, 2'd0, 16'h1008, 10'd0,  32'h8000_0000, 1'b1},
      // R4 R7 R8 mailbox word 3, zero mask
      '{2'd1, 1'b1, 64'hDEAD_BEEF_0002_000C, 32'h5555_5555, 1'b0, 2'd0, 16'h102C, 10'd2,  32'hDEAD_BEEF, 1'b0},
      // R6 mailbox word 7, keep bytes 0 and 2
      '{2'd1, 1'b1, 64'hAABB_CCDD_2805_001C, 32'h1122_3344, 1'b0, 2'd1, 16'h103C, 10'd5,  32'hAA22_CC44, 1'b0},
      // R5 R6 free address, keep all
      '{2'd2, 1'b1, 64'h1234_5678_780F_4A5C, 32'hCAFE_F00D, 1'b0, 2'd1, 16'h4A5C, 10'd15, 32'hCAFE_F00D, 1'b0},
      // R5 R6 keep byte 3 only
      '{2'd2, 1'b1, 64'h0102_0304_4001_0100, 32'h9988_7766, 1'b0, 2'd1, 16'h0100, 10'd1,  32'h9902_0304, 1'b0},
      // R4 bits 1:0 and 31 ignored
      '{2'd1, 1'b1, 64'h0000_0005_8000_0003, 32'h0,         1'b0, 2'd0, 16'h1020, 10'd0,  32'h0000_0005, 1'b0},
      // R9 narrow free-address send
      '{2'd2, 1'b0, 64'h1111_1111_0001_0200, 32'h0,         1'b1, 2'd0, 16'h0,    10'd0,  32'h0,          1'b0},
      // R10 core 16 on mailbox
      '{2'd1, 1'b1, 64'h0000_0001_0010_0000, 32'h0,         1'b1, 2'd0, 16'h0,    10'd0,  32'h0,          1'b0},
      // R10 core 1023 on interrupt
      '{2'd0, 1'b0, 64'h0000_0000_03FF_0003, 32'h0,         1'b1, 2'd0, 16'h0,    10'd0,  32'h0,          1'b0},
      // R9 reserved kind
      '{2'd3, 1'b1, 64'h0000_0000_0000_0000, 32'h0,         1'b1, 2'd0, 16'h0,    10'd0,  32'h0,          1'b0},
      // R6 mailbox word 1, keep byte 1
      '{2'd1, 1'b1, 64'h0A0B_0C0D_1009_0004, 32'hF0E0_D0C0, 1'b0, 2'd1, 16'h1024, 10'd9,  32'h0A0B_D00D, 1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_kind = '0;
   logic              cmd_wide = 1'b0;
   logic [63:0]       cmd_data = '0;
   logic              busy, done, err, irq_raise;
   logic [CORE_W-1:0] irq_core;
   logic              req_valid, req_write;
   logic [CORE_W-1:0] req_core;
   logic [ADDR_W-1:0] req_addr;
   logic [WORD_W-1:0] req_wdata;
   logic              rsp_valid;
   logic [WORD_W-1:0] rsp_rdata;

   logic              rsp_en = 1'b1;
   logic [31:0]       tgt_word = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   int          n_reads, n_writes;
   logic [15:0] rd_addr, wr_addr;
   logic [9:0]  wr_core;
   logic [31:0] wr_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rsp_valid = req_valid && rsp_en;
   assign rsp_rdata = tgt_word;

   always @(posedge clk) begin
      if (req_valid && rsp_valid) begin
         if (req_write) begin
            n_writes <= n_writes + 1;
            wr_addr  <= req_addr;
            wr_core  <= req_core;
            wr_data  <= req_wdata;
         end else begin
            n_reads <= n_reads + 1;
            rd_addr <= req_addr;
         end
      end
   end

   core_msg_sender i_core_msg_sender (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_kind  (cmd_kind),
      .cmd_wide  (cmd_wide),
      .cmd_data  (cmd_data),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .irq_raise (irq_raise),
      .irq_core  (irq_core),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_core  (req_core),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_reads  = 0;
      n_writes = 0;
      rd_addr  = '0;
      wr_addr  = '0;
      wr_core  = '0;
      wr_data  = '0;
   endtask

   // called at a negedge; offers the command for one edge
   task automatic send(input logic [1:0] k, input logic w, input logic [63:0] c);
      cmd_kind  = k;
      cmd_wide  = w;
      cmd_data  = c;
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // waits at negedges for done or err; returns which pulses were seen
   task automatic wait_end(output bit saw_done, output bit saw_err,
                           output bit saw_irq, output logic [9:0] icore);
      saw_done = 0; saw_err = 0; saw_irq = 0; icore = '0;
      for (int i = 0; i < 40; i++) begin
         if (done) begin
            saw_done = 1;
            saw_irq  = irq_raise;
            icore    = irq_core;
            break;
         end
         if (err) begin
            saw_err = 1;
            break;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit sd, se, si;
      logic [9:0] ic;
      clear_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 req_valid", 64'(req_valid), 64'd0);
      check("R1 done/err/irq", 64'({done, err, irq_raise}), 64'd0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         clear_mon();
         tgt_word = VECS[v].old;
         send(VECS[v].kind, VECS[v].wide, VECS[v].cmd);
         wait_end(sd, se, si, ic);
         @(negedge clk);
         if (VECS[v].exp_err) begin
            check($sformatf("R9/R10 err pulse v%0d", v), 64'(se), 64'd1);
            check($sformatf("R9/R10 no bus v%0d", v), 64'(n_reads + n_writes), 64'd0);
         end else begin
            check($sformatf("R12 done v%0d", v), 64'(sd), 64'd1);
            check($sformatf("R6/R7 reads v%0d", v), 64'(n_reads), 64'(VECS[v].exp_reads));
            check($sformatf("R12 one write v%0d", v), 64'(n_writes), 64'd1);
            check($sformatf("R3/R4/R5 addr v%0d", v), 64'(wr_addr), 64'(VECS[v].exp_addr));
            check($sformatf("R2 core v%0d", v), 64'(wr_core), 64'(VECS[v].exp_core));
            check($sformatf("R6/R8 data v%0d", v), 64'(wr_data), 64'(VECS[v].exp_data));
            check($sformatf("R3 irq v%0d", v), 64'(si), 64'(VECS[v].exp_irq));
            if (VECS[v].exp_irq)
               check($sformatf("R2 irq_core v%0d", v), 64'(ic), 64'(VECS[v].exp_core));
            if (VECS[v].exp_reads != 0)
               check($sformatf("R6 read addr v%0d", v), 64'(rd_addr), 64'(VECS[v].exp_addr));
            check($sformatf("R11 idle after v%0d", v), 64'(busy), 64'd0);
         end
      end

      // R11: stalled response, second command during busy is ignored
      clear_mon();
      rsp_en   = 1'b0;
      tgt_word = 32'h0102_0304;
      send(2'd1, 1'b1, 64'hA0B0_C0D0_0803_0008); // keep byte 0, core 3, word 2
      repeat (3) @(negedge clk);
      check("R11 busy while stalled", 64'(busy), 64'd1);
      check("R11 read held", 64'({req_valid, req_write}), 64'b10);
      check("R11 addr held", 64'(req_addr), 64'h1028);
      send(2'd2, 1'b1, 64'h5555_5555_0001_7777);
      check("R11 addr after ignored cmd", 64'(req_addr), 64'h1028);
      rsp_en = 1'b1;
      wait_end(sd, se, si, ic);
      check("R12 stalled done", 64'(sd), 64'd1);
      repeat (4) @(negedge clk);
      check("R11 single write", 64'(n_writes), 64'd1);
      check("R11 write addr", 64'(wr_addr), 64'h1028);
      check("R6 stalled merge", 64'(wr_data), 64'hA0B0_C004);
      check("R11 idle after", 64'(busy), 64'd0);

      // R12 done lasts one cycle
      clear_mon();
      send(2'd0, 1'b0, 64'h0000_0000_0000_0001);
      wait_end(sd, se, si, ic);
      @(negedge clk);
      check("R12 done one cycle", 64'(done), 64'd0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule